// File: doc/BRIEF.md
# MMU and Exception Control Register Bank

This block is the memory-mapped register bank that sits in front of an MMU and an exception unit. Software reaches it through a simple single-cycle bus (valid, write, byte address, byte enables, write data) and gets read data and an error flag back in the same cycle. Most registers are plain storage, but several writes have side effects. The MMU control register has a self-clearing invalidate bit. A write to the page-table-entry-high register compares the new address-space ID against the stored one. Several registers keep only the bits that are legal for them.

The block drives two one-cycle pulses towards the translation hardware, one to invalidate the TLB and one to flush it. It also holds a 16-bit refresh count that advances each time it is read. It returns three fixed identification words. It treats a small window of wait-state and memory-control addresses as harmless: writes there are dropped and reads return 0. Every other access that does not match the map, or that uses the wrong size, is rejected with an error.

Top module: `mmu_exc_regbank`

## Requirements
- R1: After reset every stored register reads 0, including the refresh count.
- R2: The MMU control register sits at offset 0x00. Bit 2 of that register is the invalidate bit. A full-word write with bit 2 set raises `tlb_inval_pulse` during the accepting cycle. The stored value never keeps bit 2, so bit 2 always reads back as 0. All other bits are stored as written.
- R3: The page-table-entry-high register sits at offset 0x04. Bits 7:0 of this register hold the address-space ID. A full-word write whose bits 7:0 differ from the stored bits 7:0 raises `tlb_flush_pulse` during the accepting cycle. A write with an equal ID raises no flush. The whole word is stored in both cases.
- R4: The page-table-entry assist register sits at offset 0x20. It keeps only bits 3:0 of a write, and all higher bits read as 0.
- R5: Three code registers keep only bits 10:0 of a write: the trap code at 0x14, the exception event at 0x18 and the interrupt event at 0x1C. Three registers keep all 32 bits: the page-table-entry-low at 0x08, the table base at 0x0C and the exception address at 0x10.
- R6: The refresh count sits at offset 0x50 and is accessed as a half word, with byte enables 0011. A read returns the count in bits 15:0 and then increments it, wrapping from 0xFFFF to 0. A write loads bits 15:0 of the write data.
- R7: Full-word reads of offsets 0x30, 0x40 and 0x44 return the processor version, cache version and processor revision constants.
- R8: The quiet window is offsets 0x60, 0x64, 0x68 and 0x6C. Full-word accesses there raise no error, reads return 0, and writes change nothing.
- R9: Some accesses raise `rsp_err` in the same cycle and return read data 0: a misaligned address, an unmapped address, byte enables other than 1111 on a 32-bit location, byte enables other than 0011 on the refresh count, and a write to an identification word. Such an access changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the control space |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rsp_err | output | 1 | Access rejected |
| tlb_inval_pulse | output | 1 | One-cycle TLB invalidate request |
| tlb_flush_pulse | output | 1 | One-cycle TLB flush request |

## Verification
Directed sequences cover each side effect in isolation. An MMU control write is tried with the invalidate bit both set and clear, which separates the pulse from the stored value. Writes to the entry-high register with an equal ID and then a different ID show that the flush depends on the compare and not on the write alone. Back-to-back refresh reads and a load of 0xFFFF expose increment and wrap errors. A long random mix of addresses, byte enables and write data, checked against a bench model, distinguishes mis-decoded offsets, wrong masks and partial writes that leak into storage.

// File: rtl/mxr_pkg.sv
package mxr_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_REG,
      K_ID,
      K_RFC,
      K_QUIET
   } acc_kind_e;

   localparam int NREG      = 9;
   localparam int OFS_ID0   = 'h30;
   localparam int OFS_ID1   = 'h40;
   localparam int OFS_ID2   = 'h44;
   localparam int OFS_RFC   = 'h50;
   localparam int OFS_QLO   = 'h60;
   localparam int OFS_QHI   = 'h6C;

   // index order of stored registers: ctl, ptehi, ptelo, base, exc addr,
   // trap, exc event, int event, assist (offset = 4 * index)
   function automatic logic [31:0] keep_mask(int i, int inval_bit,
                                             int code_w, int assist_w);
      case (i)
         0:       return ~(32'd1 << inval_bit);
         5, 6, 7: return (32'd1 << code_w) - 32'd1;
         8:       return (32'd1 << assist_w) - 32'd1;
         default: return '1;
      endcase
   endfunction

endpackage

// File: rtl/mxr_field_reg.sv
module mxr_field_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d & KEEP;
   end
endmodule

// File: rtl/mxr_refresh_ctr.sv
module mxr_refresh_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         bump,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (bump) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mxr_decode.sv
module mxr_decode #(
   parameter int ADDR_W = 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_be,
   output logic              hit,
   output logic              err,
   output mxr_pkg::acc_kind_e kind,
   output logic [3:0]        idx
);
   import mxr_pkg::*;

   logic aligned, full, half, legal;

   assign aligned = (req_addr[1:0] == 2'b00);
   assign full    = (req_be == 4'hF);
   assign half    = (req_be == 4'h3);

   always_comb begin
      kind  = K_NONE;
      idx   = '0;
      legal = 1'b0;
      if (aligned) begin
         if (int'(req_addr[ADDR_W-1:2]) < NREG) begin
            kind  = K_REG;
            idx   = 4'(req_addr[ADDR_W-1:2]);
            legal = full;
         end else if (req_addr == ADDR_W'(OFS_ID0)) begin
            kind  = K_ID;
            idx   = 4'd0;
            legal = full && !req_write;
         end else if (req_addr == ADDR_W'(OFS_ID1)) begin
            kind  = K_ID;
            idx   = 4'd1;
            legal = full && !req_write;
         end else if (req_addr == ADDR_W'(OFS_ID2)) begin
            kind  = K_ID;
            idx   = 4'd2;
            legal = full && !req_write;
         end else if (req_addr == ADDR_W'(OFS_RFC)) begin
            kind  = K_RFC;
            legal = half;
         end else if (req_addr >= ADDR_W'(OFS_QLO) && req_addr <= ADDR_W'(OFS_QHI)) begin
            kind  = K_QUIET;
            legal = full;
         end
      end
   end

   assign hit = req_valid && legal;
   assign err = req_valid && !legal;
endmodule

// File: rtl/mmu_exc_regbank.sv
module mmu_exc_regbank #(
   parameter int          ADDR_W    = 8,
   parameter int          INVAL_BIT = 2,
   parameter int          ASID_W    = 8,
   parameter int          CODE_W    = 11,
   parameter int          ASSIST_W  = 4,
   parameter int          RFC_W     = 16,
   parameter logic [31:0] PROC_ID   = 32'h0402_05C1,
   parameter logic [31:0] CACHE_ID  = 32'h2048_0000,
   parameter logic [31:0] REV_ID    = 32'h0000_0113
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_be,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic              tlb_inval_pulse,
   output logic              tlb_flush_pulse
);
   import mxr_pkg::*;

   localparam int DW = 32;

   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 7..16");
   end
   if (INVAL_BIT < 0 || INVAL_BIT >= DW) begin : g_bad_inval
      $error("INVAL_BIT outside the word");
   end
   if (ASID_W < 1 || ASID_W > DW || CODE_W < 1 || CODE_W >= DW) begin : g_bad_fld
      $error("ASID_W or CODE_W out of range");
   end
   if (ASSIST_W < 1 || ASSIST_W >= DW || RFC_W < 1 || RFC_W > 16) begin : g_bad_small
      $error("ASSIST_W or RFC_W out of range");
   end

   logic               hit, wr_ok, rd_ok;
   acc_kind_e          kind;
   logic [3:0]         idx;
   logic [NREG-1:0]    reg_we;
   logic [NREG-1:0][DW-1:0] regs_q;
   logic [RFC_W-1:0]   rfc_q;
   logic [DW-1:0]      mmuctl_q, ptehi_q, assist_q;

   mxr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .hit       (hit),
      .err       (rsp_err),
      .kind      (kind),
      .idx       (idx)
   );

   assign wr_ok = hit && req_write;
   assign rd_ok = hit && !req_write;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] KM = keep_mask(i, INVAL_BIT, CODE_W, ASSIST_W);
      assign reg_we[i] = wr_ok && (kind == K_REG) && (idx == 4'(i));
      mxr_field_reg #(.W(DW), .KEEP(KM)) u_fld (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (reg_we[i]),
         .d     (req_wdata),
         .q     (regs_q[i])
      );
   end

   assign mmuctl_q = regs_q[0];
   assign ptehi_q  = regs_q[1];
   assign assist_q = regs_q[8];

   mxr_refresh_ctr #(.W(RFC_W)) u_rfc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_ok && (kind == K_RFC)),
      .load_val (req_wdata[RFC_W-1:0]),
      .bump     (rd_ok && (kind == K_RFC)),
      .cnt      (rfc_q)
   );

   assign tlb_inval_pulse = reg_we[0] && req_wdata[INVAL_BIT];
   assign tlb_flush_pulse = reg_we[1] &&
                            (req_wdata[ASID_W-1:0] != ptehi_q[ASID_W-1:0]);

   always_comb begin
      rsp_rdata = '0;
      if (rd_ok) begin
         case (kind)
            K_REG:   rsp_rdata = regs_q[idx];
            K_ID: begin
               case (idx)
                  4'd0:    rsp_rdata = PROC_ID;
                  4'd1:    rsp_rdata = CACHE_ID;
                  default: rsp_rdata = REV_ID;
               endcase
            end
            K_RFC:   rsp_rdata = DW'(rfc_q);
            default: rsp_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mxr_checker.sv
module mxr_checker #(
   parameter int ADDR_W    = 8,
   parameter int INVAL_BIT = 2,
   parameter int ASID_W    = 8,
   parameter int ASSIST_W  = 4,
   parameter int RFC_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [31:0]       req_wdata,
   input logic              rsp_err,
   input logic              tlb_inval_pulse,
   input logic              tlb_flush_pulse,
   input logic [31:0]       mmuctl_q,
   input logic [31:0]       ptehi_q,
   input logic [31:0]       assist_q,
   input logic [RFC_W-1:0]  rfc_q
);
   logic rfc_read;
   assign rfc_read = req_valid && !req_write && !rsp_err &&
                     (req_addr == ADDR_W'(mxr_pkg::OFS_RFC));

   // R2
   a_r2_inval_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_inval_pulse |=> (mmuctl_q[INVAL_BIT] == 1'b0));
   // R2
   a_r2_inval_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_inval_pulse |-> (req_valid && req_write && req_wdata[INVAL_BIT]));
   // R3
   a_r3_flush_on_new_asid: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush_pulse |=> ((ptehi_q[ASID_W-1:0] == $past(req_wdata[ASID_W-1:0])) &&
                           (ptehi_q[ASID_W-1:0] != $past(ptehi_q[ASID_W-1:0]))));
   // R4
   a_r4_assist_width: assert property (@(posedge clk) disable iff (!rst_n)
      assist_q[31:ASSIST_W] == '0);
   // R6
   a_r6_refresh_bump: assert property (@(posedge clk) disable iff (!rst_n)
      rfc_read |=> (rfc_q == RFC_W'($past(rfc_q) + 1'b1)));
   // R9
   a_r9_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!tlb_inval_pulse && !tlb_flush_pulse));
   // R9
   a_r9_err_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |=> ($stable(mmuctl_q) && $stable(ptehi_q) && $stable(rfc_q) &&
                   $stable(assist_q)));
endmodule

bind mmu_exc_regbank mxr_checker #(
   .ADDR_W    (ADDR_W),
   .INVAL_BIT (INVAL_BIT),
   .ASID_W    (ASID_W),
   .ASSIST_W  (ASSIST_W),
   .RFC_W     (RFC_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_write       (req_write),
   .req_addr        (req_addr),
   .req_wdata       (req_wdata),
   .rsp_err         (rsp_err),
   .tlb_inval_pulse (tlb_inval_pulse),
   .tlb_flush_pulse (tlb_flush_pulse),
   .mmuctl_q        (mmuctl_q),
   .ptehi_q         (ptehi_q),
   .assist_q        (assist_q),
   .rfc_q           (rfc_q)
);

// File: tb/sim_mmu_exc_regbank.sv
module sim_mmu_exc_regbank;
   localparam logic [31:0] P_ID = 32'h0402_05C1;
   localparam logic [31:0] C_ID = 32'h2048_0000;
   localparam logic [31:0] R_ID = 32'h0000_0113;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_err, tlb_inval_pulse, tlb_flush_pulse;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [31:0] m_reg [9];
   logic [15:0] m_rfc;

   always #2 clk = ~clk;

   mmu_exc_regbank u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .tlb_inval_pulse(tlb_inval_pulse), .tlb_flush_pulse(tlb_flush_pulse));

   function automatic logic [31:0] keep(int i);
      case (i)
         0:       return 32'hFFFF_FFFB;
         5, 6, 7: return 32'h0000_07FF;
         8:       return 32'h0000_000F;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   // model one access: returns expected outputs, updates model state
   task automatic model(input bit wr, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output bit er, output bit inv, output bit fl,
                        output string tg);
      int w;
      bit full, half;
      w = int'(a >> 2);
      full = (be == 4'hF);
      half = (be == 4'h3);
      rd = '0; er = 0; inv = 0; fl = 0; tg = "R9";
      if (a[1:0] != 2'b00) er = 1;
      else if (w < 9) begin
         tg = (w == 0) ? "R2" : (w == 1) ? "R3" : (w == 8) ? "R4" : "R5";
         if (!full) begin er = 1; tg = "R9"; end
         else if (!wr) rd = m_reg[w];
         else begin
            if (w == 0) inv = wd[2];
            if (w == 1) fl = (wd[7:0] != m_reg[1][7:0]);
            m_reg[w] = wd & keep(w);
         end
      end else if (a == 8'h30 || a == 8'h40 || a == 8'h44) begin
         tg = "R7";
         if (!full || wr) begin er = 1; tg = "R9"; end
         else rd = (a == 8'h30) ? P_ID : (a == 8'h40) ? C_ID : R_ID;
      end else if (a == 8'h50) begin
         tg = "R6";
         if (!half) begin er = 1; tg = "R9"; end
         else if (wr) m_rfc = wd[15:0];
         else begin rd = {16'h0, m_rfc}; m_rfc = m_rfc + 16'd1; end
      end else if (a >= 8'h60 && a <= 8'h6C) begin
         tg = "R8";
         if (!full) begin er = 1; tg = "R9"; end
      end else er = 1;
   endtask

   task automatic acc(input bit wr, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input string tag_in);
      logic [31:0] e_rd;
      bit e_er, e_inv, e_fl;
      string tg;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
      model(wr, a, be, wd, e_rd, e_er, e_inv, e_fl, tg);
      if (tag_in != "") tg = tag_in;
      #1;
      checks++;
      if (rsp_rdata !== e_rd || rsp_err !== e_er ||
          tlb_inval_pulse !== e_inv || tlb_flush_pulse !== e_fl) begin
         errors++;
         $display("FAIL %s addr=%h wr=%0d be=%h: got rd=%h err=%0d inv=%0d fl=%0d exp rd=%h err=%0d inv=%0d fl=%0d",
                  tg, a, wr, be, rsp_rdata, rsp_err, tlb_inval_pulse, tlb_flush_pulse,
                  e_rd, e_er, e_inv, e_fl);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] pool [20];
      void'($urandom(32'd4242));
      for (int i = 0; i < 9; i++) m_reg[i] = '0;
      m_rfc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int i = 0; i < 9; i++) acc(0, 8'(i * 4), 4'hF, '0, "R1");
      acc(0, 8'h50, 4'h3, '0, "R1");

      // R2: invalidate bit set, then clear
      acc(1, 8'h00, 4'hF, 32'hFFFF_FFFF, "R2");
      acc(0, 8'h00, 4'hF, '0, "R2");
      acc(1, 8'h00, 4'hF, 32'h0000_0101, "R2");
      acc(0, 8'h00, 4'hF, '0, "R2");

      // R3: new ASID, same ASID, different ASID again
      acc(1, 8'h04, 4'hF, 32'h1234_5677, "R3");
      acc(1, 8'h04, 4'hF, 32'hABCD_0077, "R3");
      acc(0, 8'h04, 4'hF, '0, "R3");
      acc(1, 8'h04, 4'hF, 32'hABCD_0078, "R3");

      // R4, R5: masking
      acc(1, 8'h20, 4'hF, 32'hFFFF_FFFF, "R4");
      acc(0, 8'h20, 4'hF, '0, "R4");
      acc(1, 8'h14, 4'hF, 32'hFFFF_FFFF, "R5");
      acc(0, 8'h14, 4'hF, '0, "R5");
      acc(1, 8'h1C, 4'hF, 32'hDEAD_BEEF, "R5");
      acc(0, 8'h1C, 4'hF, '0, "R5");
      acc(1, 8'h10, 4'hF, 32'hDEAD_BEEF, "R5");
      acc(0, 8'h10, 4'hF, '0, "R5");

      // R6: increment on read, wrap
      acc(0, 8'h50, 4'h3, '0, "R6");
      acc(0, 8'h50, 4'h3, '0, "R6");
      acc(1, 8'h50, 4'h3, 32'h5555_FFFF, "R6");
      acc(0, 8'h50, 4'h3, '0, "R6");
      acc(0, 8'h50, 4'h3, '0, "R6");

      // R7: identification words
      acc(0, 8'h30, 4'hF, '0, "R7");
      acc(0, 8'h40, 4'hF, '0, "R7");
      acc(0, 8'h44, 4'hF, '0, "R7");

      // R8: quiet window
      acc(1, 8'h64, 4'hF, 32'hFFFF_FFFF, "R8");
      acc(0, 8'h64, 4'hF, '0, "R8");
      acc(0, 8'h6C, 4'hF, '0, "R8");

      // R9: rejected accesses leave state alone
      acc(1, 8'h00, 4'h3, 32'h0000_0004, "R9");
      acc(0, 8'h00, 4'hF, '0, "R9");
      acc(1, 8'h30, 4'hF, 32'h1, "R9");
      acc(0, 8'h50, 4'hF, '0, "R9");
      acc(0, 8'h50, 4'h3, '0, "R9");
      acc(1, 8'h06, 4'hF, 32'h99, "R9");
      acc(0, 8'h74, 4'hF, '0, "R9");
      acc(1, 8'h04, 4'h1, 32'h0000_00FF, "R9");
      acc(0, 8'h04, 4'hF, '0, "R9");

      // random mix against the model
      for (int i = 0; i < 9; i++) pool[i] = 8'(i * 4);
      pool[9] = 8'h30; pool[10] = 8'h40; pool[11] = 8'h44; pool[12] = 8'h50;
      pool[13] = 8'h60; pool[14] = 8'h68; pool[15] = 8'h6C; pool[16] = 8'h50;
      pool[17] = 8'h04; pool[18] = 8'h00; pool[19] = 8'h24;
      for (int n = 0; n < 600; n++) begin
         logic [7:0]  a;
         logic [3:0]  be;
         logic [31:0] wd;
         int          sel;
         sel = int'($urandom_range(0, 21));
         a = (sel < 20) ? pool[sel] : 8'($urandom);
         case ($urandom_range(0, 3))
            0, 1:    be = (a == 8'h50) ? 4'h3 : 4'hF;
            2:       be = 4'h3;
            default: be = 4'($urandom);
         endcase
         wd = $urandom;
         if (a == 8'h04 && $urandom_range(0, 1) == 1) wd[7:0] = m_reg[1][7:0];
         acc(bit'($urandom_range(0, 1)), a, be, wd, "");
      end

      @(negedge clk);
      req_valid = 1'b0;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule